// File: doc/BRIEF.md
# Power-state to quiescence channel converter

This block sits between a power controller that issues power-state requests and a device that only understands a quiescence handshake. The controller raises a request together with an 8-bit state code. The block decodes that code into a single goal for the device: running or quiescent. It then drives the device's active-low request to reach that goal and reports the outcome to the controller as accept or deny.

The goal is the AND of two build-time 16-bit masks. One mask is indexed by the low nibble of the state, which is the power mode. The other is indexed by the high nibble, which is the operating mode. A 32-bit activity output repeats the device activity input on each bit enabled by a third mask. Optional two-flop synchronizers can be placed on the controller request input. A second, separately enabled set can be placed on the device accept and deny inputs.

Top module: `pq_bridge`

## Requirements
- R1: The goal is running only when PWR_MASK[ctl_state_i[3:0]] and OPM_MASK[ctl_state_i[7:4]] are both 1; otherwise the goal is quiescent. Both masks default to 16'h01F0, so the goal is running only when both nibbles are in the range 4 to 8.
- R2: If the goal equals the present device state, the block asserts ctl_accept_o and dev_req_no does not change during the transaction.
- R3: For a goal of quiescent from running, the block drives dev_req_no low. When dev_accept_ni goes low it asserts ctl_accept_o, and the device state becomes quiescent.
- R4: While the block waits for quiescence, a high dev_deny_i makes it assert ctl_deny_o and drive dev_req_no high again. The device state stays running.
- R5: For a goal of running from quiescent, the block drives dev_req_no high. When dev_accept_ni goes high it asserts ctl_accept_o, and the device state becomes running.
- R6: ctl_accept_o or ctl_deny_o stays high while ctl_req_i stays high, and clears once ctl_req_i falls. The two are never high together.
- R7: Each bit of ctl_active_o equals dev_active_i where ACT_MASK has a 1 and is 0 where it has a 0. ACT_MASK defaults to all ones.
- R8: During and after reset, dev_req_no, ctl_accept_o and ctl_deny_o are low, and the device is taken as quiescent.
- R9: When a request needs no device handshake, ctl_accept_o rises on the third clock edge after ctl_req_i rises if the request synchronizer is on (CTL_SYNC=1). It rises on the first edge if CTL_SYNC=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_req_i | input | 1 | Controller request |
| ctl_state_i | input | 8 | Requested state: [3:0] power mode, [7:4] operating mode |
| ctl_accept_o | output | 1 | Controller accept |
| ctl_deny_o | output | 1 | Controller deny |
| ctl_active_o | output | ACT_W | Masked copies of device activity |
| dev_req_no | output | 1 | Device request, low requests quiescence |
| dev_accept_ni | input | 1 | Device accept, low when quiescent |
| dev_deny_i | input | 1 | Device deny |
| dev_active_i | input | 1 | Device activity |

## Verification
A wrongly held device state shows up within one transaction. The next request then either toggles dev_req_no when no handshake was needed, or answers at once when a handshake was due. The bench sweeps all 256 state codes from both device states, with the device set to accept and then to deny, and compares each answer and the final dev_req_no level against a goal worked out from the nibble ranges. A decode or synchronizer fault moves the answer by a whole cycle, and the cycle-exact latency checks catch it.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TO_Q, ST_TO_R, ST_ACC, ST_DENY
  } pq_state_e;
endpackage

// File: rtl/pq_sync.sv
module pq_sync #(
  parameter bit          EN     = 1'b1,
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (EN) begin : g_sync
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
    assign q_o = chain_q[STAGES-1];
  end else begin : g_bypass
    assign q_o = d_i;
  end
endmodule

// File: rtl/pq_target.sv
module pq_target #(
  parameter int unsigned        NIB_W    = 4,
  parameter logic [15:0]        PWR_MASK = 16'h01F0,
  parameter logic [15:0]        OPM_MASK = 16'h01F0
) (
  input  logic [2*NIB_W-1:0] state_i,
  output logic               run_o
);
  logic [NIB_W-1:0] pwr_idx, opm_idx;
  assign pwr_idx = state_i[NIB_W-1:0];
  assign opm_idx = state_i[2*NIB_W-1:NIB_W];
  assign run_o   = PWR_MASK[pwr_idx] & OPM_MASK[opm_idx];
endmodule

// File: rtl/pq_fsm.sv
module pq_fsm
  import pq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic goal_run_i,
  input  logic acc_n_i,
  input  logic deny_i,
  output logic dev_req_no,
  output logic accept_o,
  output logic deny_o
);
  pq_state_e st_q;
  logic      run_q, req_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      run_q  <= 1'b0;
      req_nq <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          if (goal_run_i == run_q) st_q <= ST_ACC;
          else if (goal_run_i) begin
            req_nq <= 1'b1;
            st_q   <= ST_TO_R;
          end else begin
            req_nq <= 1'b0;
            st_q   <= ST_TO_Q;
          end
        end
        ST_TO_Q: begin
          if (!acc_n_i) begin
            run_q <= 1'b0;
            st_q  <= ST_ACC;
          end else if (deny_i) begin
            req_nq <= 1'b1;  // withdraw the quiescence request
            st_q   <= ST_DENY;
          end
        end
        ST_TO_R: if (acc_n_i) begin
          run_q <= 1'b1;
          st_q  <= ST_ACC;
        end
        ST_ACC, ST_DENY: if (!req_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign dev_req_no = req_nq;
  assign accept_o   = (st_q == ST_ACC);
  assign deny_o     = (st_q == ST_DENY);
endmodule

// File: rtl/pq_bridge.sv
module pq_bridge #(
  parameter int unsigned STATE_W  = 8,
  parameter int unsigned ACT_W    = 32,
  parameter logic [15:0] PWR_MASK = 16'h01F0,
  parameter logic [15:0] OPM_MASK = 16'h01F0,
  parameter logic [ACT_W-1:0] ACT_MASK = '1,
  parameter bit          CTL_SYNC = 1'b1,
  parameter bit          DEV_SYNC = 1'b1,
  parameter int unsigned STAGES   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctl_req_i,
  input  logic [STATE_W-1:0] ctl_state_i,
  output logic               ctl_accept_o,
  output logic               ctl_deny_o,
  output logic [ACT_W-1:0]   ctl_active_o,
  output logic               dev_req_no,
  input  logic               dev_accept_ni,
  input  logic               dev_deny_i,
  input  logic               dev_active_i
);
  localparam int unsigned NIB_W = STATE_W / 2;

  logic req_s, acc_n_s, deny_s, goal_run;

  pq_sync #(.EN(CTL_SYNC), .STAGES(STAGES)) u_sync_req (
    .clk_i, .rst_ni, .d_i(ctl_req_i), .q_o(req_s));
  pq_sync #(.EN(DEV_SYNC), .STAGES(STAGES)) u_sync_acc (
    .clk_i, .rst_ni, .d_i(dev_accept_ni), .q_o(acc_n_s));
  pq_sync #(.EN(DEV_SYNC), .STAGES(STAGES)) u_sync_deny (
    .clk_i, .rst_ni, .d_i(dev_deny_i), .q_o(deny_s));

  pq_target #(.NIB_W(NIB_W), .PWR_MASK(PWR_MASK), .OPM_MASK(OPM_MASK)) u_target (
    .state_i(ctl_state_i), .run_o(goal_run));

  pq_fsm u_fsm (
    .clk_i, .rst_ni,
    .req_i(req_s), .goal_run_i(goal_run), .acc_n_i(acc_n_s), .deny_i(deny_s),
    .dev_req_no, .accept_o(ctl_accept_o), .deny_o(ctl_deny_o));

  for (genvar i = 0; i < ACT_W; i++) begin : g_act
    if (ACT_MASK[i]) begin : g_on
      assign ctl_active_o[i] = dev_active_i;
    end else begin : g_off
      assign ctl_active_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pq_bridge_chk.sv
module pq_bridge_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_s,
  input logic acc_n_s,
  input logic ctl_accept_o,
  input logic ctl_deny_o,
  input logic dev_req_no
);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_accept_o && ctl_deny_o));
  a_r6_accept_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_accept_o && req_s) |=> ctl_accept_o);
  a_r6_deny_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_deny_o && req_s) |=> ctl_deny_o);
  a_r2_accept_no_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_accept_o) |-> $stable(dev_req_no));
  a_r4_deny_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_deny_o) |-> dev_req_no);
  a_r3_quiet_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctl_accept_o) && !dev_req_no) |-> !acc_n_s);
  a_r5_run_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctl_accept_o) && dev_req_no) |-> acc_n_s);
endmodule

bind pq_bridge pq_bridge_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_s(req_s), .acc_n_s(acc_n_s),
  .ctl_accept_o(ctl_accept_o), .ctl_deny_o(ctl_deny_o), .dev_req_no(dev_req_no));

// File: tb/sim_pq_bridge.sv
module sim_pq_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       req = 1'b0, act = 1'b0;
  logic [7:0] st = '0;
  logic       acc, dny, dreq_n;
  logic [31:0] active;
  logic       d_acc_n, d_deny, deny_mode = 1'b0;

  logic        req1 = 1'b0;
  logic        acc1, dny1, dreq1_n;
  logic [31:0] active1;
  localparam logic [31:0] MASK1 = 32'hA5A5_0F0F;

  int checks = 0, errors = 0;
  bit dev_run = 1'b0;

  pq_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_req_i(req), .ctl_state_i(st),
    .ctl_accept_o(acc), .ctl_deny_o(dny), .ctl_active_o(active),
    .dev_req_no(dreq_n), .dev_accept_ni(d_acc_n), .dev_deny_i(d_deny),
    .dev_active_i(act));

  pq_bridge #(.ACT_MASK(MASK1), .CTL_SYNC(1'b0), .DEV_SYNC(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_req_i(req1), .ctl_state_i(8'h00),
    .ctl_accept_o(acc1), .ctl_deny_o(dny1), .ctl_active_o(active1),
    .dev_req_no(dreq1_n), .dev_accept_ni(1'b0), .dev_deny_i(1'b0),
    .dev_active_i(act));

  // device model: accepts or denies quiescence per deny_mode
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_acc_n <= 1'b0; d_deny <= 1'b0;
    end else if (dreq_n) begin
      d_deny <= 1'b0; d_acc_n <= 1'b1;
    end else if (d_acc_n && !d_deny) begin
      if (deny_mode) d_deny <= 1'b1;
      else           d_acc_n <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint actv, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
    end
  endtask

  function automatic bit goal(input logic [7:0] s);
    return (s[3:0] >= 4 && s[3:0] <= 8) && (s[7:4] >= 4 && s[7:4] <= 8);
  endfunction

  task automatic xact(input logic [7:0] s);
    bit g, toggled, got_acc, got_dny, start_rn;
    int n;
    g = goal(s);
    start_rn = dreq_n;
    toggled = 1'b0;
    @(negedge clk); st = s; req = 1'b1;
    n = 0;
    while (!acc && !dny && n < 40) begin
      @(negedge clk); n++;
      if (dreq_n != start_rn) toggled = 1'b1;
    end
    got_acc = acc; got_dny = dny;
    if (g == dev_run) begin
      chk(got_acc && !toggled, "R1 R2 match accept no toggle", {got_acc, toggled}, 2'b10);
    end else if (!g && deny_mode) begin
      chk(got_dny && dreq_n, "R1 R4 deny restores request", {got_dny, dreq_n}, 2'b11);
    end else if (!g) begin
      chk(got_acc && !dreq_n, "R1 R3 quiescent accept", {got_acc, dreq_n}, 2'b10);
      dev_run = 1'b0;
    end else begin
      chk(got_acc && dreq_n, "R1 R5 running accept", {got_acc, dreq_n}, 2'b11);
      dev_run = 1'b1;
    end
    repeat (4) @(negedge clk);
    chk((acc == got_acc) && (dny == got_dny) && !(acc && dny), "R6 hold",
        {acc, dny}, {got_acc, got_dny});
    req = 1'b0;
    repeat (4) @(negedge clk);
    chk(!acc && !dny, "R6 clear", {acc, dny}, 2'b00);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!dreq_n && !acc && !dny, "R8 reset u0", {dreq_n, acc, dny}, 3'b000);
    chk(!dreq1_n && !acc1 && !dny1, "R8 reset u1", {dreq1_n, acc1, dny1}, 3'b000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 latency, quiescent goal against quiescent device
    st = 8'h00; req = 1'b1; req1 = 1'b1;
    @(negedge clk);
    chk(acc1, "R9 no sync first edge", acc1, 1);
    chk(!acc, "R9 sync edge1", acc, 0);
    @(negedge clk);
    chk(!acc, "R9 sync edge2", acc, 0);
    @(negedge clk);
    chk(acc, "R9 sync edge3", acc, 1);
    req = 1'b0; req1 = 1'b0;
    @(negedge clk);
    chk(!acc1, "R6 u1 clear next edge", acc1, 0);
    repeat (4) @(negedge clk);

    // R7 activity masks
    for (int v = 0; v < 2; v++) begin
      act = v[0];
      #1;
      chk(active == {32{v[0]}}, "R7 full mask", active, {32{v[0]}});
      chk(active1 == (MASK1 & {32{v[0]}}), "R7 partial mask", active1, MASK1 & {32{v[0]}});
    end

    // full sweep, accept then deny device behaviour
    for (int m = 0; m < 2; m++) begin
      deny_mode = m[0];
      for (int s = 0; s < 256; s++) xact(s[7:0]);
      for (int s = 255; s >= 0; s--) xact(s[7:0]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule